// File: doc/BRIEF.md
# Nested Four-Level Interrupt Arbiter

This block picks which of seven interrupt requests is handed to the processor. Software gives each source a level from 0 to 3 using two 7-bit priority vectors, one holding the upper bit of every level and one holding the lower bit. Arbitration happens only when the sampling strobe is high, which marks the end of a sampling cycle. At that edge the block chooses one winner and emits a one-cycle dispatch pulse that carries the winner's index and level.

The block also keeps a mask of the levels whose handlers are running. A dispatch marks its level as busy. A return-from-interrupt pulse releases the highest busy level. A request can only win if its level is strictly above every busy level, so a running handler is preempted only by something more urgent. A level-3 handler is never preempted.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset, `disp_valid` is 0 and `in_service` is 0000.
- R2: The level of source i is the 2-bit value {`prio_hi[i]`, `prio_lo[i]`}, so 3 is the most urgent. `disp_level` reports the winner's level as sampled at the strobe.
- R3: A dispatch happens only at a clock edge where `sample_stb` is 1. `disp_valid` is then high for the following cycle only, unless the next edge is also a winning strobe.
- R4: Source i can win only if `irq_req[i]`, `irq_en[i]` and `glb_en` are all 1.
- R5: While any level is in service, a request can win only if its level is greater than the highest in-service level. Requests at equal or lower levels produce no dispatch.
- R6: While level 3 is in service, no dispatch occurs.
- R7: Among the eligible requests, the one with the highest level wins.
- R8: Among eligible requests at the same level, the lowest index wins. Index 0 is the most urgent and index 6 the least. `disp_idx` carries the bit position of the winner in the request vector.
- R9: A dispatch sets bit `disp_level` of `in_service` (bit k stands for level k).
- R10: A `ret_i` pulse clears the highest set bit of `in_service`. If a dispatch happens at the same edge, the new level's bit is set as well. Eligibility at that edge uses the mask from before the return.
- R11: `in_service` changes only at edges where `sample_stb` or `ret_i` is high. Writing the priority vectors does not alter it, and the new levels apply from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 7 | Request line per source |
| irq_en | input | 7 | Enable bit per source |
| glb_en | input | 1 | Global interrupt enable |
| prio_hi | input | 7 | Upper level bit per source |
| prio_lo | input | 7 | Lower level bit per source |
| sample_stb | input | 1 | End-of-sampling-cycle strobe |
| ret_i | input | 1 | Return-from-interrupt pulse |
| disp_valid | output | 1 | Dispatch pulse |
| disp_idx | output | 3 | Index of the dispatched source |
| disp_level | output | 2 | Level of the dispatched source |
| in_service | output | 4 | One bit per level currently in service |

## Verification
The dispatch outputs and the in-service mask are registered at the same edge that sees `sample_stb`. They therefore show the decision one cycle after the strobe was driven, and they hold it until the next edge. A return updates the mask at the edge where `ret_i` is high. The bench drives every input just after a falling edge and keeps the strobe or return high for exactly one rising edge. It then reads the results at the next falling edge, which lies midway through the cycle in which they are valid. The bench also runs windows of several idle cycles and confirms that the mask holds still and that no dispatch appears.

// File: rtl/nia_pkg.sv
package nia_pkg;
  localparam int SRC_N    = 7;
  localparam int LVL_BITS = 2;
endpackage

// File: rtl/nia_level_map.sv
module nia_level_map #(
  parameter int NS = 7,
  parameter int LW = 2
) (
  input  logic [NS-1:0]    hi_bits,
  input  logic [NS-1:0]    lo_bits,
  output logic [NS*LW-1:0] lvl_flat
);
  function automatic logic [LW-1:0] join_level(input logic h, input logic l);
    logic [LW-1:0] v;
    v = '0;
    v[LW-1] = h;
    v[0] = l;
    return v;
  endfunction

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign lvl_flat[i*LW +: LW] = join_level(hi_bits[i], lo_bits[i]);
  end
endmodule

// File: rtl/nia_pick.sv
module nia_pick #(
  parameter int NS = 7,
  parameter int LW = 2,
  parameter int IW = 3
) (
  input  logic [NS-1:0]    elig,
  input  logic [NS*LW-1:0] lvl_flat,
  output logic             any,
  output logic [IW-1:0]    idx,
  output logic [LW-1:0]    lvl
);
  function automatic logic [LW-1:0] level_at(input logic [NS*LW-1:0] f, input int i);
    return f[i*LW +: LW];
  endfunction

  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = 0; i < NS; i++) begin
      if (elig[i] && (!any || level_at(lvl_flat, i) > lvl)) begin
        any = 1'b1;
        idx = IW'(i);
        lvl = level_at(lvl_flat, i);
      end
    end
  end
endmodule

// File: rtl/nia_service.sv
module nia_service #(
  parameter int LW = 2,
  localparam int NL = 1 << LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [NL-1:0] mask,
  output logic [LW-1:0] top,
  output logic          busy
);
  function automatic logic [LW-1:0] top_index(input logic [NL-1:0] m);
    logic [LW-1:0] t;
    t = '0;
    for (int k = 0; k < NL; k++) if (m[k]) t = LW'(k);
    return t;
  endfunction

  function automatic logic [NL-1:0] drop_top(input logic [NL-1:0] m);
    logic [NL-1:0] r;
    r = m;
    if (|m) r[top_index(m)] = 1'b0;
    return r;
  endfunction

  logic [NL-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask;
    if (pop) mask_nxt = drop_top(mask);
    if (push) mask_nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nxt;
  end

  assign top  = top_index(mask);
  assign busy = |mask;
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter #(
  parameter int NUM_SRC = nia_pkg::SRC_N,
  parameter int LVL_W   = nia_pkg::LVL_BITS,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic               sample_stb,
  input  logic               ret_i,
  output logic               disp_valid,
  output logic [IDX_W-1:0]   disp_idx,
  output logic [LVL_W-1:0]   disp_level,
  output logic [NUM_LVL-1:0] in_service
);
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic [NUM_SRC-1:0]       elig_vec;
  logic [LVL_W-1:0]         svc_top;
  logic                     svc_busy;
  logic                     pick_any;
  logic [IDX_W-1:0]         pick_idx;
  logic [LVL_W-1:0]         pick_lvl;
  logic                     dispatch_fire;

  nia_level_map #(.NS(NUM_SRC), .LW(LVL_W)) u_map (
    .hi_bits(prio_hi), .lo_bits(prio_lo), .lvl_flat(lvl_flat)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig_vec[i] = irq_req[i] & irq_en[i] & glb_en &
                         (!svc_busy || (lvl_flat[i*LVL_W +: LVL_W] > svc_top));
  end

  nia_pick #(.NS(NUM_SRC), .LW(LVL_W), .IW(IDX_W)) u_pick (
    .elig(elig_vec), .lvl_flat(lvl_flat),
    .any(pick_any), .idx(pick_idx), .lvl(pick_lvl)
  );

  assign dispatch_fire = sample_stb & pick_any;

  nia_service #(.LW(LVL_W)) u_svc (
    .clk(clk), .rst_n(rst_n),
    .push(dispatch_fire), .push_lvl(pick_lvl), .pop(ret_i),
    .mask(in_service), .top(svc_top), .busy(svc_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_idx   <= '0;
      disp_level <= '0;
    end else begin
      disp_valid <= dispatch_fire;
      if (dispatch_fire) begin
        disp_idx   <= pick_idx;
        disp_level <= pick_lvl;
      end
    end
  end
endmodule

// File: rtl/nia_checker.sv
module nia_checker #(
  parameter int NUM_SRC = 7,
  parameter int LVL_W   = 2,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] prio_hi,
  input logic [NUM_SRC-1:0] prio_lo,
  input logic               sample_stb,
  input logic               ret_i,
  input logic               disp_valid,
  input logic [IDX_W-1:0]   disp_idx,
  input logic [LVL_W-1:0]   disp_level,
  input logic [NUM_LVL-1:0] in_service,
  input logic [NUM_SRC-1:0] elig_vec
);
  function automatic logic bit_at(input logic [NUM_SRC-1:0] v, input logic [IDX_W-1:0] i);
    return v[i];
  endfunction

  assert_level_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_level[LVL_W-1] == bit_at($past(prio_hi), disp_idx)) &&
                   (disp_level[0] == bit_at($past(prio_lo), disp_idx)));

  assert_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(sample_stb));

  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> bit_at($past(elig_vec), disp_idx));

  assert_strict_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (($past(in_service) >> disp_level) == '0));

  assert_top_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_service[NUM_LVL-1]) |-> !disp_valid);

  assert_mark_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> in_service[disp_level]);

  assert_pop_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_i) && !disp_valid && ($past(in_service) != '0)) |->
      ($countones(in_service) == $countones($past(in_service)) - 1));

  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sample_stb) && !$past(ret_i)) |-> $stable(in_service));
endmodule

bind nest_irq_arbiter nia_checker #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio_hi(prio_hi), .prio_lo(prio_lo),
  .sample_stb(sample_stb), .ret_i(ret_i), .disp_valid(disp_valid),
  .disp_idx(disp_idx), .disp_level(disp_level), .in_service(in_service),
  .elig_vec(elig_vec)
);

// File: tb/nest_irq_arbiter_tb.sv
module nest_irq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_req = '0, irq_en = '0, prio_hi = '0, prio_lo = '0;
  logic       glb_en = 1'b0, sample_stb = 1'b0, ret_i = 1'b0;
  logic       disp_valid;
  logic [2:0] disp_idx;
  logic [1:0] disp_level;
  logic [3:0] in_service;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_mask = '0;

  always #10 clk = ~clk;

  nest_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .glb_en(glb_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
    .sample_stb(sample_stb), .ret_i(ret_i), .disp_valid(disp_valid),
    .disp_idx(disp_idx), .disp_level(disp_level), .in_service(in_service)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: scan levels from most urgent down, indices upward.
  task automatic model_pick(output bit any, output int idx, output int lvl);
    int ceiling;
    any = 0; idx = 0; lvl = 0;
    ceiling = -1;
    for (int k = 0; k < 4; k++) if (m_mask[k]) ceiling = k;
    for (int lv = 3; lv >= 0 && !any; lv--) begin
      for (int i = 0; i < 7 && !any; i++) begin
        if (irq_req[i] && irq_en[i] && glb_en && (2*prio_hi[i] + prio_lo[i]) == lv && lv > ceiling) begin
          any = 1; idx = i; lvl = lv;
        end
      end
    end
  endtask

  task automatic model_pop();
    for (int k = 3; k >= 0; k--) if (m_mask[k]) begin m_mask[k] = 1'b0; break; end
  endtask

  task automatic strobe_chk(input string req, input bit with_ret = 0);
    bit any; int idx; int lvl;
    model_pick(any, idx, lvl);
    sample_stb = 1'b1;
    ret_i = with_ret;
    @(negedge clk);
    sample_stb = 1'b0;
    ret_i = 1'b0;
    if (with_ret) model_pop();
    if (any) m_mask[lvl] = 1'b1;
    check(disp_valid == any, req, disp_valid, any);
    if (any) begin
      check(disp_idx == idx, req, disp_idx, idx);
      check(disp_level == lvl, req, disp_level, lvl);
    end
    check(in_service == m_mask, {req, " mask"}, in_service, m_mask);
  endtask

  task automatic ret_chk(input string req);
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
    model_pop();
    check(in_service == m_mask, req, in_service, m_mask);
  endtask

  task automatic set_levels(input int l0, input int l1, input int l2, input int l3,
                            input int l4, input int l5, input int l6);
    int l[7];
    l = '{l0, l1, l2, l3, l4, l5, l6};
    for (int i = 0; i < 7; i++) begin
      prio_hi[i] = l[i][1];
      prio_lo[i] = l[i][0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(disp_valid == 1'b0, "R1 valid", disp_valid, 0);
    check(in_service == 4'b0, "R1 mask", in_service, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep all request patterns under several level configurations (R2 R7 R8).
    irq_en = 7'h7F; glb_en = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      prio_hi = 7'((cfg * 43) & 127);
      prio_lo = 7'(((cfg * 89) ^ 21) & 127);
      for (int pat = 0; pat < 128; pat++) begin
        irq_req = 7'(pat);
        strobe_chk("R2 R7 R8");
        if (m_mask != 0) ret_chk("R10 sweep");
      end
    end

    // Enable sweep with all sources requesting (R4).
    irq_req = 7'h7F; set_levels(1, 1, 1, 1, 1, 1, 1);
    for (int e = 0; e < 128; e++) begin
      irq_en = 7'(e);
      strobe_chk("R4 enable");
      if (m_mask != 0) ret_chk("R10 enable");
    end
    irq_en = 7'h7F; glb_en = 1'b0;
    strobe_chk("R4 global off");
    glb_en = 1'b1;

    // No strobe: no dispatch, mask untouched (R3 R11).
    irq_req = 7'b0000100; set_levels(0, 0, 1, 0, 0, 0, 0);
    strobe_chk("R9 dispatch level1");
    irq_req = 7'b0100000; set_levels(0, 0, 1, 0, 0, 2, 0);
    repeat (3) @(negedge clk);
    check(disp_valid == 1'b0, "R3 no strobe", disp_valid, 0);
    check(in_service == 4'b0010, "R11 hold", in_service, 4'b0010);

    // Priority rewrite leaves the mask alone (R11).
    set_levels(3, 3, 3, 3, 3, 3, 2);
    repeat (2) @(negedge clk);
    check(in_service == 4'b0010, "R11 prio rewrite", in_service, 4'b0010);
    set_levels(0, 0, 1, 0, 0, 2, 0);

    // Strictly higher preempts, equal waits (R5).
    strobe_chk("R5 higher preempts");
    irq_req = 7'b0000001; set_levels(2, 0, 1, 0, 0, 2, 0);
    strobe_chk("R5 equal waits");
    check(disp_valid == 1'b0, "R5 equal", disp_valid, 0);
    irq_req = 7'b1000000; set_levels(0, 0, 0, 0, 0, 0, 3);
    strobe_chk("R5 level3 preempts");
    irq_req = 7'h7F; set_levels(3, 3, 3, 3, 3, 3, 3);
    strobe_chk("R6 level3 blocks");
    check(disp_valid == 1'b0, "R6 blocked", disp_valid, 0);
    check(in_service == 4'b1110, "R9 nested mask", in_service, 4'b1110);

    // Pops release highest first (R10).
    irq_req = '0;
    ret_chk("R10 pop3");
    ret_chk("R10 pop2");
    // Return and dispatch at the same edge (R10).
    irq_req = 7'b0001000; set_levels(0, 0, 0, 2, 0, 0, 0);
    strobe_chk("R10 simultaneous", 1);
    ret_chk("R10 pop after");
    ret_chk("R10 empty pop");

    // Dispatch pulse is one cycle long (R3).
    @(negedge clk);
    check(disp_valid == 1'b0, "R3 pulse end", disp_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule